// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block is the integer multiply engine that sits beside a 32-bit core's integer pipeline. It holds a 64-bit accumulator as two 32-bit registers, HI (upper half) and LO (lower half). For each accepted request it computes a 64-bit result from two 32-bit operands and the current accumulator, writes that result back into HI and LO, and returns one half of the new value for a general-register destination. Four operation classes are supported: a plain product, a negated product, accumulator plus product, and accumulator minus product. Each class has a signed and an unsigned form. A per-request bit chooses whether the returned half is HI or LO.

Requests arrive one at a time with a valid strobe. Every result appears one clock after the request is sampled, together with a single-cycle result-valid pulse. A side port loads HI or LO directly for test and for restoring context. It yields to a real operation in the same cycle. Register file, decode, traps and hazard handling belong to the surrounding pipeline.

Top module: `macc_hilo_unit`

## Requirements
- R1: A synchronous active-high reset clears HI, LO, the returned value and the result-valid output to zero.
- R2: The 4-bit operation code is decoded as follows:
  - bits 1:0 select the class: 00 is product, 01 is negated product, 10 is accumulate-add, 11 is accumulate-subtract.
  - bit 2 set selects the unsigned form.
  - bit 3 set returns HI; clear returns LO.
- R3: Signed forms sign-extend both operands to 64 bits before multiplying. Unsigned forms zero-extend them.
- R4: Results wrap modulo 2^64 with no saturation:
  - product gives P.
  - negated product gives 0 - P.
  - accumulate-add gives {HI,LO} + P.
  - accumulate-subtract gives {HI,LO} - P.
- R5: When an operation is sampled with the request valid high, the result is loaded on that same clock edge, with bits 63:32 into HI and bits 31:0 into LO. `hiOut`, `loOut` and a one-cycle `resValid` pulse show it during the following cycle.
- R6: The returned value `resData` equals the new HI when code bit 3 is set and the new LO when it is clear. It holds its last value between results.
- R7: Codes 0x0 and 0x4 (product class with LO return) are reserved. A request carrying one changes neither HI nor LO, does not change `resData` and raises no `resValid`.
- R8: With no valid operation, `wrEn` high loads `wrData` into HI when `wrSelHi` is 1, or into LO when it is 0, on that clock edge. The other half is left unchanged and no `resValid` is raised.
- R9: A direct load and a valid non-reserved operation in the same cycle: only the operation's result is stored, and the load is dropped.
- R10: HI and LO do not change in any cycle that has neither an operation nor a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Operation request strobe |
| opCode | input | 4 | Operation code (see R2) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| wrEn | input | 1 | Direct load enable |
| wrSelHi | input | 1 | Direct load target: 1 selects HI, 0 selects LO |
| wrData | input | 32 | Direct load data |
| resValid | output | 1 | One-cycle pulse marking a new returned value |
| resData | output | 32 | Returned half of the new accumulator |
| hiOut | output | 32 | Current HI register |
| loOut | output | 32 | Current LO register |

## Verification
The bench goes after operand values 0x80000000 and 0xFFFFFFFF in signed and unsigned forms:
- A design that zero-extends where it should sign-extend returns 0xFFFFFFFE00000001 instead of 1 for the signed square of 0xFFFFFFFF.
- A design that sign-extends an unsigned operand gets the reverse.

It also covers the accumulator boundaries:
- It loads an all-ones accumulator and adds one. A design that saturates, or drops the carry from LO into HI, leaves something other than zero.
- It subtracts from zero, where a broken borrow shows at once.

Reserved codes and load/operation collisions are mixed in among the random requests. A design that lets the load win, or executes a reserved code, then drifts away from the bench's reference accumulator.

// File: rtl/macc_pkg.sv
package macc_pkg;

  typedef enum logic [1:0] {
    CLS_MUL = 2'b00,
    CLS_NEG = 2'b01,
    CLS_ADD = 2'b10,
    CLS_SUB = 2'b11
  } opClass_e;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic     doOp;
    logic     isUnsigned;
    opClass_e cls;
    logic     retHi;
    logic     loadHi;
    logic     loadLo;
  } maccStrobe_t;

endpackage

// File: rtl/macc_ctrl.sv
module macc_ctrl
  import macc_pkg::*;
(
  input  logic        reqValid,
  input  logic [3:0]  opCode,
  input  logic        wrEn,
  input  logic        wrSelHi,
  output maccStrobe_t strobe
);

  opClass_e codeCls;
  logic     reservedCode;

  assign codeCls      = opClass_e'(opCode[1:0]);
  // Product class exists only with HI return.
  assign reservedCode = (codeCls == CLS_MUL) && !opCode[3];

  always_comb begin
    strobe.doOp       = reqValid && !reservedCode;
    strobe.isUnsigned = opCode[2];
    strobe.cls        = codeCls;
    strobe.retHi      = opCode[3];
    // An accepted operation takes precedence over the load port.
    strobe.loadHi     = wrEn &&  wrSelHi && !strobe.doOp;
    strobe.loadLo     = wrEn && !wrSelHi && !strobe.doOp;
  end

endmodule

// File: rtl/macc_datapath.sv
module macc_datapath
  import macc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  maccStrobe_t  strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] hiQ,
  output logic [W-1:0] loQ,
  output logic [W-1:0] resData,
  output logic         resValid
);

  localparam int AW = 2 * W;

  logic [AW-1:0] extA, extB, product, base, accNext;
  logic          doSub, retHiS, loadHiS, loadLoS, doOpS;

  assign doOpS   = strobe.doOp;
  assign retHiS  = strobe.retHi;
  assign loadHiS = strobe.loadHi;
  assign loadLoS = strobe.loadLo;

  // Operand extension: sign or zero fill of the upper half.
  assign extA = strobe.isUnsigned ? {{W{1'b0}}, opA} : {{W{opA[W-1]}}, opA};
  assign extB = strobe.isUnsigned ? {{W{1'b0}}, opB} : {{W{opB[W-1]}}, opB};

  // Low AW bits of the extended product are exact for both forms.
  assign product = extA * extB;

  always_comb begin
    base  = '0;
    doSub = 1'b0;
    unique case (strobe.cls)
      CLS_MUL: begin base = '0;          doSub = 1'b0; end
      CLS_NEG: begin base = '0;          doSub = 1'b1; end
      CLS_ADD: begin base = {hiQ, loQ};  doSub = 1'b0; end
      CLS_SUB: begin base = {hiQ, loQ};  doSub = 1'b1; end
    endcase
    accNext = doSub ? (base - product) : (base + product);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiQ      <= '0;
      loQ      <= '0;
      resData  <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= doOpS;
      if (doOpS) begin
        hiQ     <= accNext[AW-1:W];
        loQ     <= accNext[W-1:0];
        resData <= retHiS ? accNext[AW-1:W] : accNext[W-1:0];
      end else begin
        if (loadHiS) hiQ <= wrData;
        if (loadLoS) loQ <= wrData;
      end
    end
  end

  // R6
  ret_half_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resData == ($past(retHiS) ? hiQ : loQ)));

  // R5
  pulse_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    doOpS |=> resValid);

  // R9
  load_yields_chk: assert property (@(posedge clk) disable iff (rst)
    doOpS |-> !(loadHiS || loadLoS));

  // R8
  load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({loadHiS, loadLoS}));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(doOpS) && !$past(loadHiS) && !$past(loadLoS))
      |-> ($stable(hiQ) && $stable(loQ) && !resValid));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (hiQ == '0 && loQ == '0 && resData == '0 && !resValid));

endmodule

// File: rtl/macc_hilo_unit.sv
module macc_hilo_unit
  import macc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic [3:0]   opCode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         wrEn,
  input  logic         wrSelHi,
  input  logic [W-1:0] wrData,
  output logic         resValid,
  output logic [W-1:0] resData,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);

  maccStrobe_t strobe;

  macc_ctrl u_ctrl (
    .reqValid (reqValid),
    .opCode   (opCode),
    .wrEn     (wrEn),
    .wrSelHi  (wrSelHi),
    .strobe   (strobe)
  );

  macc_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .wrData   (wrData),
    .hiQ      (hiOut),
    .loQ      (loOut),
    .resData  (resData),
    .resValid (resValid)
  );

endmodule

// File: tb/macc_hilo_unit_tb.sv
module macc_hilo_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic [3:0]  opCode;
  logic [31:0] opA, opB, wrData;
  logic        wrEn, wrSelHi;
  logic        resValid;
  logic [31:0] resData, hiOut, loOut;

  int checks = 0;
  int fails  = 0;

  logic [63:0] accM;
  logic [31:0] resM;

  always #10 clk = ~clk;

  macc_hilo_unit u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .opCode(opCode),
    .opA(opA), .opB(opB), .wrEn(wrEn), .wrSelHi(wrSelHi), .wrData(wrData),
    .resValid(resValid), .resData(resData), .hiOut(hiOut), .loOut(loOut)
  );

  function automatic logic [63:0] refCalc(logic [3:0] c, logic [31:0] a,
                                          logic [31:0] b, logic [63:0] acc);
    logic [63:0] p;
    longint sa, sb;
    if (c[2]) p = {32'h0, a} * {32'h0, b};
    else begin
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      p  = 64'(sa * sb);
    end
    case (c[1:0])
      2'd0:    return p;
      2'd1:    return 64'd0 - p;
      2'd2:    return acc + p;
      default: return acc - p;
    endcase
  endfunction

  function automatic bit isReserved(logic [3:0] c);
    return (c[1:0] == 2'b00) && !c[3];
  endfunction

  task automatic check64(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag, bit expValid);
    check64({hiOut, loOut} == accM, {tag, " hi:lo"}, {hiOut, loOut}, accM);
    check64(resValid == expValid, "R5 resValid", 64'(resValid), 64'(expValid));
    check64(resData == resM, "R6 resData", 64'(resData), 64'(resM));
  endtask

  // One request cycle, optional simultaneous load, then sample a cycle later.
  task automatic step(bit v, logic [3:0] c, logic [31:0] a, logic [31:0] b,
                      bit lw, bit lsel, logic [31:0] ld, string tag);
    bit expValid;
    @(negedge clk);
    reqValid = v; opCode = c; opA = a; opB = b;
    wrEn = lw; wrSelHi = lsel; wrData = ld;
    expValid = 1'b0;
    if (v && !isReserved(c)) begin
      accM     = refCalc(c, a, b, accM);
      resM     = c[3] ? accM[63:32] : accM[31:0];
      expValid = 1'b1;
    end else if (lw) begin
      if (lsel) accM[63:32] = ld;
      else      accM[31:0]  = ld;
    end
    @(negedge clk);
    reqValid = 1'b0; wrEn = 1'b0;
    checkAll(tag, expValid);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] corner [4];
    corner[0] = 32'h8000_0000; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h0000_0000; corner[3] = 32'h7FFF_FFFF;
    void'($urandom(32'd20240611));
    rst = 1'b1; reqValid = 0; opCode = 0; opA = 0; opB = 0;
    wrEn = 0; wrSelHi = 0; wrData = 0;
    accM = 64'd0; resM = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checkAll("R1 reset", 1'b0);
    rst = 1'b0;

    // R3 signed and unsigned corner operands, product class returning HI (R2)
    step(1, 4'b1000, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, "R3 signed 0x80000000^2");
    check64(accM == 64'h4000_0000_0000_0000, "R3 model", accM, 64'h4000_0000_0000_0000);
    step(1, 4'b1000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R3 signed -1*-1");
    step(1, 4'b1100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R3 unsigned max^2");
    step(1, 4'b1000, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0, "R3 signed min*-1");
    step(1, 4'b1100, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0, "R3 unsigned");
    // R4 negated product both returns (R6)
    step(1, 4'b0001, 32'd3, 32'd5, 0, 0, 0, "R4 neg lo");
    step(1, 4'b1101, 32'hFFFF_FFFF, 32'd2, 0, 0, 0, "R4 negu hi");
    // R8 direct loads, then R4 wrap on add
    step(0, 4'b0000, 0, 0, 1, 1, 32'hFFFF_FFFF, "R8 load hi");
    step(0, 4'b0000, 0, 0, 1, 0, 32'hFFFF_FFFF, "R8 load lo");
    step(1, 4'b0110, 32'd1, 32'd1, 0, 0, 0, "R4 add wrap to zero");
    step(1, 4'b1011, 32'd1, 32'd1, 0, 0, 0, "R4 sub wrap below zero");
    // R7 reserved codes leave state alone
    step(1, 4'b0000, 32'd7, 32'd9, 0, 0, 0, "R7 reserved 0x0");
    step(1, 4'b0100, 32'd7, 32'd9, 0, 0, 0, "R7 reserved 0x4");
    // R9 collision: operation wins
    step(1, 4'b1010, 32'd2, 32'd3, 1, 1, 32'h1234_5678, "R9 op beats load hi");
    step(1, 4'b0011, 32'd2, 32'd3, 1, 0, 32'h1234_5678, "R9 op beats load lo");
    // R10 idle cycle
    step(0, 4'b1111, 32'd5, 32'd5, 0, 0, 0, "R10 idle");

    for (int i = 0; i < 400; i++) begin
      logic [3:0]  c;
      logic [31:0] a, b, d;
      bit v, lw, ls;
      string tag;
      c  = 4'($urandom % 16);
      a  = ($urandom % 3 == 0) ? corner[$urandom % 4] : $urandom;
      b  = ($urandom % 3 == 0) ? corner[$urandom % 4] : $urandom;
      v  = ($urandom % 8) != 0;
      lw = ($urandom % 4) == 0;
      ls = 1'($urandom % 2);
      d  = $urandom;
      if (v && isReserved(c))      tag = "R7 random reserved";
      else if (v && lw)            tag = "R9 random collision";
      else if (v)                  tag = "R4 random op";
      else if (lw)                 tag = "R8 random load";
      else                         tag = "R10 random idle";
      step(v, c, a, b, lw, ls, d, tag);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule